// File: doc/BRIEF.md
# Interrupting GPIO Bank with Sleep and Fault Output Overrides

This block is one bank of sixteen general-purpose pins behind a simple synchronous register bus. Software picks each pin's direction and drive value, and reads the synchronized pad levels back. Every pin feeds an interrupt detector. The detector sees either a level or a single edge, and software chooses the polarity for each pin. Detected events are latched per pin. The latched bits pass through a per-pin mask and are ORed onto a single interrupt line.

Two system conditions change the bank's behaviour. While the sleep input is high, a separate sleep interrupt mask takes the place of the normal mask, and the pins drive a dedicated sleep value. While the battery-fault input is high, the pins drive a dedicated fault value, and this override wins over sleep. Register writes take effect on the clock edge at which the write strobe is high. Reads are combinational from the address.

Top module: `gpio_bank_irq`

## Requirements
- R1: Reset clears every register to zero except the normal and sleep interrupt masks, which reset to all ones. In the first cycle after reset, irq_o is low and pin_oe is zero.
- R2: A 1 in the direction register (offset 0x00) makes that pin an output on pin_oe. With neither sleep nor fault active, pin_out equals the drive register (offset 0x04), where 0 drives low. Both registers read back as written.
- R3: The level register (offset 0x28, read-only) returns pin_in after a two-flop synchronizer, so a change shows after two clock edges.
- R4: For a pin with mode bit 1 (edge, offset 0x10) and edge-polarity bit 1 (offset 0x14), a rising transition sets that pin's status bit (offset 0x24) on the third clock edge after the change. A falling transition does not set it. The bit then holds until it is cleared.
- R5: For a pin with mode bit 1 and edge-polarity bit 0, a falling transition sets its status bit and a rising transition does not.
- R6: For a pin with mode bit 0 (level), level-polarity bit 1 (offset 0x18) detects a high input and 0 detects a low input. The status bit is set again while the condition persists, even after a clear.
- R7: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. If a new event arrives in the same cycle as a clear, the event wins.
- R8: irq_o is the OR of all status bits whose interrupt mask bit (offset 0x1C) is 0. A mask bit of 1 masks the pin.
- R9: While sleep_i is high, the sleep interrupt mask (offset 0x20) is used in place of the normal mask.
- R10: While sleep_i is high and batt_fault_i is low, pin_out equals the sleep drive register (offset 0x08).
- R11: While batt_fault_i is high, pin_out equals the fault drive register (offset 0x0C), whatever the state of sleep_i.
- R12: Reads of offsets 0x2C and 0x30 return zero. Writes to those offsets change no other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pin_in | input | 16 | Pad input levels (asynchronous) |
| pin_out | output | 16 | Pad drive values |
| pin_oe | output | 16 | Pad output enables (1 = drive) |
| sleep_i | input | 1 | Sleep condition |
| batt_fault_i | input | 1 | Battery-fault condition |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong synchronizer depth or edge reference shows as a status bit that appears one cycle early or late, or never appears at all. The directed tests sample on the exact edge, so this is seen within four cycles of a pad change. A status bit that fails to hold, or that a zero write clears, shows on the next status read and through irq_o as soon as the mask is opened. Mask selection and output-override errors appear on irq_o and pin_out in the same cycle as the sleep or fault input changes, because both paths are combinational from registered state.

// File: rtl/gb_pkg.sv
package gb_pkg;

    localparam int GB_PINS = 16;
    localparam int GB_AW   = 8;
    localparam int GB_DW   = GB_PINS;
    localparam int GB_SYNC = 2;

    typedef enum logic [GB_AW-1:0] {
        OFF_DIR     = 8'h00,
        OFF_DRV     = 8'h04,
        OFF_SLP_DRV = 8'h08,
        OFF_FLT_DRV = 8'h0C,
        OFF_MODE    = 8'h10,
        OFF_EPOL    = 8'h14,
        OFF_LPOL    = 8'h18,
        OFF_MASK    = 8'h1C,
        OFF_SMASK   = 8'h20,
        OFF_STAT    = 8'h24,
        OFF_LEVEL   = 8'h28
    } gb_off_e;

    typedef struct packed {
        logic [GB_PINS-1:0] dir;
        logic [GB_PINS-1:0] drv;
        logic [GB_PINS-1:0] slp_drv;
        logic [GB_PINS-1:0] flt_drv;
        logic [GB_PINS-1:0] mode;
        logic [GB_PINS-1:0] epol;
        logic [GB_PINS-1:0] lpol;
        logic [GB_PINS-1:0] mask;
        logic [GB_PINS-1:0] smask;
    } gb_cfg_t;

    typedef struct packed {
        logic               cur;
        logic               prev;
        logic               mode;
        logic               epol;
        logic               lpol;
    } gb_pin_view_t;

    // Event for one pin from its synchronized samples and its configuration
    function automatic logic gb_event(input gb_pin_view_t v);
        logic hit;
        if (v.mode) begin
            hit = v.epol ? (v.cur & ~v.prev) : (~v.cur & v.prev);
        end else begin
            hit = v.lpol ? v.cur : ~v.cur;
        end
        return hit;
    endfunction

endpackage

// File: rtl/gb_sync.sv
module gb_sync #(
    parameter int W      = gb_pkg::GB_PINS,
    parameter int STAGES = gb_pkg::GB_SYNC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] chain [STAGES];
    logic [W-1:0] last;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= '0;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last <= '0;
        else     last <= chain[STAGES-1];
    end

    assign q      = chain[STAGES-1];
    assign q_prev = last;
endmodule

// File: rtl/gb_pin_detect.sv
module gb_pin_detect
    import gb_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  gb_pin_view_t view,
    input  logic         clr,
    output logic         evt,
    output logic         stat
);
    assign evt = gb_event(view);

    always_ff @(posedge clk) begin
        if (rst)      stat <= 1'b0;
        else if (evt) stat <= 1'b1;
        else if (clr) stat <= 1'b0;
    end
endmodule

// File: rtl/gb_regfile.sv
module gb_regfile
    import gb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [GB_AW-1:0]   bus_addr,
    input  logic [GB_DW-1:0]   bus_wdata,
    output logic [GB_DW-1:0]   bus_rdata,
    input  logic [GB_PINS-1:0] status,
    input  logic [GB_PINS-1:0] levels,
    output gb_cfg_t            cfg,
    output logic [GB_PINS-1:0] clr_vec
);
    localparam logic [GB_PINS-1:0] ONES = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            cfg.mask  <= ONES;
            cfg.smask <= ONES;
        end else if (bus_wr) begin
            case (bus_addr)
                OFF_DIR:     cfg.dir     <= bus_wdata;
                OFF_DRV:     cfg.drv     <= bus_wdata;
                OFF_SLP_DRV: cfg.slp_drv <= bus_wdata;
                OFF_FLT_DRV: cfg.flt_drv <= bus_wdata;
                OFF_MODE:    cfg.mode    <= bus_wdata;
                OFF_EPOL:    cfg.epol    <= bus_wdata;
                OFF_LPOL:    cfg.lpol    <= bus_wdata;
                OFF_MASK:    cfg.mask    <= bus_wdata;
                OFF_SMASK:   cfg.smask   <= bus_wdata;
                default:     ;
            endcase
        end
    end

    assign clr_vec = (bus_wr && bus_addr == OFF_STAT) ? bus_wdata : '0;

    always_comb begin
        case (bus_addr)
            OFF_DIR:     bus_rdata = cfg.dir;
            OFF_DRV:     bus_rdata = cfg.drv;
            OFF_SLP_DRV: bus_rdata = cfg.slp_drv;
            OFF_FLT_DRV: bus_rdata = cfg.flt_drv;
            OFF_MODE:    bus_rdata = cfg.mode;
            OFF_EPOL:    bus_rdata = cfg.epol;
            OFF_LPOL:    bus_rdata = cfg.lpol;
            OFF_MASK:    bus_rdata = cfg.mask;
            OFF_SMASK:   bus_rdata = cfg.smask;
            OFF_STAT:    bus_rdata = status;
            OFF_LEVEL:   bus_rdata = levels;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gb_out_sel.sv
module gb_out_sel
    import gb_pkg::*;
(
    input  gb_cfg_t            cfg,
    input  logic [GB_PINS-1:0] status,
    input  logic               sleep_i,
    input  logic               batt_fault_i,
    output logic [GB_PINS-1:0] pin_out,
    output logic [GB_PINS-1:0] pin_oe,
    output logic               irq_o
);
    logic [GB_PINS-1:0] live_mask;

    always_comb begin
        if (batt_fault_i)  pin_out = cfg.flt_drv;
        else if (sleep_i)  pin_out = cfg.slp_drv;
        else               pin_out = cfg.drv;
    end

    assign pin_oe    = cfg.dir;
    assign live_mask = sleep_i ? cfg.smask : cfg.mask;
    assign irq_o     = |(status & ~live_mask);
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
    import gb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_wr,
    input  logic [GB_AW-1:0]   bus_addr,
    input  logic [GB_DW-1:0]   bus_wdata,
    output logic [GB_DW-1:0]   bus_rdata,
    input  logic [GB_PINS-1:0] pin_in,
    output logic [GB_PINS-1:0] pin_out,
    output logic [GB_PINS-1:0] pin_oe,
    input  logic               sleep_i,
    input  logic               batt_fault_i,
    output logic               irq_o
);
    gb_cfg_t            cfg;
    logic [GB_PINS-1:0] lvl_cur;
    logic [GB_PINS-1:0] lvl_prev;
    logic [GB_PINS-1:0] clr_vec;
    logic [GB_PINS-1:0] evt_vec;
    logic [GB_PINS-1:0] status_q;

    gb_sync #(.W(GB_PINS), .STAGES(GB_SYNC)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d      (pin_in),
        .q      (lvl_cur),
        .q_prev (lvl_prev)
    );

    gb_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .status    (status_q),
        .levels    (lvl_cur),
        .cfg       (cfg),
        .clr_vec   (clr_vec)
    );

    genvar p;
    generate
        for (p = 0; p < GB_PINS; p++) begin : g_pin
            gb_pin_view_t view;
            assign view.cur  = lvl_cur[p];
            assign view.prev = lvl_prev[p];
            assign view.mode = cfg.mode[p];
            assign view.epol = cfg.epol[p];
            assign view.lpol = cfg.lpol[p];

            gb_pin_detect u_det (
                .clk  (clk),
                .rst  (rst),
                .view (view),
                .clr  (clr_vec[p]),
                .evt  (evt_vec[p]),
                .stat (status_q[p])
            );
        end
    endgenerate

    gb_out_sel u_out (
        .cfg          (cfg),
        .status       (status_q),
        .sleep_i      (sleep_i),
        .batt_fault_i (batt_fault_i),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe),
        .irq_o        (irq_o)
    );
endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk
    import gb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [GB_AW-1:0]   bus_addr,
    input logic [GB_DW-1:0]   bus_wdata,
    input logic [GB_PINS-1:0] pin_out,
    input logic [GB_PINS-1:0] pin_oe,
    input logic               sleep_i,
    input logic               batt_fault_i,
    input logic               irq_o,
    input logic [GB_PINS-1:0] status_q,
    input logic [GB_PINS-1:0] evt_vec,
    input logic [GB_PINS-1:0] mode_q,
    input logic [GB_PINS-1:0] flt_drv_q
);
    logic [GB_PINS-1:0] clr_seen;
    assign clr_seen = (bus_wr && bus_addr == OFF_STAT) ? bus_wdata : '0;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_o && pin_oe == '0));

    // R2
    oe_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_wr) |-> $stable(pin_oe));

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((($past(status_q) & $past(mode_q) & ~$past(clr_seen)) & ~status_q) == '0));

    // R7
    set_needs_event_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~$past(status_q) & ~$past(evt_vec)) == '0));

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (status_q != '0));

    // R11
    fault_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (batt_fault_i && sleep_i) |-> (pin_out == flt_drv_q));
endmodule

bind gpio_bank_irq gpio_bank_irq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .sleep_i      (sleep_i),
    .batt_fault_i (batt_fault_i),
    .irq_o        (irq_o),
    .status_q     (status_q),
    .evt_vec      (evt_vec),
    .mode_q       (cfg.mode),
    .flt_drv_q    (cfg.flt_drv)
);

// File: tb/gpio_bank_irq_test.sv
`timescale 1ns/1ps
module gpio_bank_irq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = 16'h0000;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic        sleep_i = 1'b0;
    logic        batt_fault_i = 1'b0;
    logic        irq_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    gpio_bank_irq uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .sleep_i(sleep_i),
        .batt_fault_i(batt_fault_i), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 irq", {15'd0, irq_o}, 16'h0000);
        check("R1 oe", pin_oe, 16'h0000);
        check("R1 out", pin_out, 16'h0000);
        rd(8'h1C, v); check("R1 mask", v, 16'hFFFF);
        rd(8'h20, v); check("R1 smask", v, 16'hFFFF);
        rd(8'h10, v); check("R1 mode", v, 16'h0000);
    endtask

    task automatic t_dir_drive();
        logic [15:0] v;
        wr(8'h00, 16'h00F0);
        wr(8'h04, 16'h00A5);
        #1;
        check("R2 oe", pin_oe, 16'h00F0);
        check("R2 out", pin_out, 16'h00A5);
        rd(8'h04, v); check("R2 readback", v, 16'h00A5);
    endtask

    task automatic t_levels();
        logic [15:0] v;
        @(negedge clk); pin_in = 16'h1234;
        @(posedge clk); #1;
        bus_addr = 8'h28; #1;
        check("R3 one edge", bus_rdata, 16'h0000);
        @(posedge clk); #1;
        check("R3 two edges", bus_rdata, 16'h1234);
        @(negedge clk); pin_in = 16'h0000;
        settle();
        rd(8'h28, v); check("R3 back low", v, 16'h0000);
    endtask

    task automatic t_edges();
        logic [15:0] v;
        wr(8'h10, 16'hFFFF);
        wr(8'h14, 16'h0001);
        settle();
        wr(8'h24, 16'hFFFF);
        rd(8'h24, v); check("R7 all clear", v, 16'h0000);
        @(negedge clk); pin_in = 16'h0001;
        @(posedge clk); @(posedge clk); #1;
        bus_addr = 8'h24; #1;
        check("R4 not yet", bus_rdata, 16'h0000);
        @(posedge clk); #1;
        check("R4 rising set", bus_rdata, 16'h0001);
        @(negedge clk); pin_in = 16'h0003;
        settle();
        rd(8'h24, v); check("R5 rise ignored", v, 16'h0001);
        @(negedge clk); pin_in = 16'h0001;
        settle();
        rd(8'h24, v); check("R5 falling set", v, 16'h0003);
        @(negedge clk); pin_in = 16'h0000;
        repeat (10) @(negedge clk);
        rd(8'h24, v); check("R4 hold", v, 16'h0003);
    endtask

    task automatic t_clear();
        logic [15:0] v;
        wr(8'h24, 16'h0001);
        rd(8'h24, v); check("R7 clear one", v, 16'h0002);
        wr(8'h24, 16'h0000);
        rd(8'h24, v); check("R7 zero write", v, 16'h0002);
        wr(8'h24, 16'h0002);
        rd(8'h24, v); check("R7 clear two", v, 16'h0000);
    endtask

    task automatic t_level_mode();
        logic [15:0] v;
        wr(8'h18, 16'hFFFF);
        wr(8'h10, 16'h0000);
        settle();
        wr(8'h24, 16'hFFFF);
        rd(8'h24, v); check("R6 idle", v, 16'h0000);
        @(negedge clk); pin_in = 16'h0010;
        settle();
        rd(8'h24, v); check("R6 high detect", v, 16'h0010);
        wr(8'h24, 16'h0010);
        settle();
        rd(8'h24, v); check("R6 reassert", v, 16'h0010);
        @(negedge clk); pin_in = 16'h0000;
        settle();
        wr(8'h24, 16'h0010);
        rd(8'h24, v); check("R6 gone", v, 16'h0000);
        wr(8'h18, 16'hFFEF);
        settle();
        rd(8'h24, v); check("R6 low detect", v, 16'h0010);
    endtask

    task automatic t_irq();
        wr(8'h1C, 16'hFFFF); #1;
        check("R8 masked", {15'd0, irq_o}, 16'h0000);
        wr(8'h1C, 16'hFFEF); #1;
        check("R8 unmasked", {15'd0, irq_o}, 16'h0001);
        @(negedge clk); sleep_i = 1'b1; #1;
        check("R9 sleep mask blocks", {15'd0, irq_o}, 16'h0000);
        wr(8'h20, 16'hFFEF); #1;
        check("R9 sleep mask opens", {15'd0, irq_o}, 16'h0001);
        wr(8'h1C, 16'hFFFF); #1;
        check("R9 normal mask unused", {15'd0, irq_o}, 16'h0001);
        @(negedge clk); sleep_i = 1'b0; #1;
        check("R8 back to normal", {15'd0, irq_o}, 16'h0000);
    endtask

    task automatic t_overrides();
        wr(8'h08, 16'h3C3C);
        wr(8'h0C, 16'h0F0F);
        @(negedge clk); sleep_i = 1'b1; #1;
        check("R10 sleep drive", pin_out, 16'h3C3C);
        @(negedge clk); batt_fault_i = 1'b1; #1;
        check("R11 fault over sleep", pin_out, 16'h0F0F);
        @(negedge clk); sleep_i = 1'b0; #1;
        check("R11 fault alone", pin_out, 16'h0F0F);
        @(negedge clk); batt_fault_i = 1'b0; #1;
        check("R2 normal again", pin_out, 16'h00A5);
    endtask

    task automatic t_unmapped();
        logic [15:0] v;
        wr(8'h2C, 16'hFFFF);
        wr(8'h30, 16'hFFFF);
        rd(8'h2C, v); check("R12 read 2C", v, 16'h0000);
        rd(8'h30, v); check("R12 read 30", v, 16'h0000);
        rd(8'h00, v); check("R12 dir intact", v, 16'h00F0);
        rd(8'h04, v); check("R12 drive intact", v, 16'h00A5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dir_drive();
        t_levels();
        t_edges();
        t_clear();
        t_level_mode();
        t_irq();
        t_overrides();
        t_unmapped();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule